// File: doc/BRIEF.md
# Banked Vector Accumulator with Neighbour Reduction

This block collects 32-bit partial sums from a dot product unit and folds them into one of four vector banks. Every bank holds 32 lanes of signed 32-bit values. Software steers it through a command port that names an operation and a bank. A bank can be zeroed, seeded with bias values, or have a stream of partial sums added into it lane by lane. Its contents can be shipped to a neighbouring unit over an outgoing reduction link, or handed to the next block on a result stream. Partials that arrive from a neighbour can be added on top of any local bank.

All data streams move one lane per beat with a valid/ready handshake, starting at lane 0. An operation that moves data finishes only once all 32 lanes have crossed. Four independent lane engines serve the four streams: the dot product input, the incoming reduction link, the outgoing reduction link and the result output. Operations on different streams therefore overlap, even on the same bank. The one restriction is that a bank being read out is protected from new commands until the readout ends.

Top module: `banked_reducer`

## Requirements
- R1: After reset every lane of every bank is zero, `dpeReady`, `redInReady`, `redOutValid` and `resValid` are low, and `cmdReady` is high.
- R2: Opcode 0 (clear) sets all 32 lanes of the named bank to zero in the cycle it is accepted.
- R3: Opcode 1 (bias load) replaces lane k of the named bank with the k-th beat taken from the dot product stream, for k = 0..31.
- R4: Opcode 2 (accumulate) adds the k-th dot product beat into lane k, wrapping modulo 2^32, and repeated accumulates keep summing.
- R5: Opcode 3 (send) presents lanes 0..31 of the named bank in order on the outgoing reduction stream, and leaves the bank unchanged.
- R6: Opcode 4 (remote add) adds the k-th beat of the incoming reduction stream into lane k of the named bank, wrapping modulo 2^32.
- R7: Opcode 5 (drain) presents lanes 0..31 of the named bank in order on the result stream, starting the cycle after acceptance, and leaves the bank unchanged.
- R8: An operation on one bank never changes the contents of any other bank.
- R9: While a send or drain on bank b is in progress, any command naming bank b is held off (`cmdReady` low); commands naming other banks are accepted.
- R10: When the dot product stream and the incoming reduction stream update the same lane of the same bank in one cycle, both contributions land in that lane.
- R11: While an output stream has valid high and ready low, its valid and data hold steady.
- R12: A data-moving operation ends exactly after its 32nd beat; until then a second command needing the same stream is held off.
- R13: Opcodes 6 and 7 are accepted and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command accepted this cycle when high with cmdValid |
| cmdOp | input | 3 | Operation code (0..7) |
| cmdBank | input | 2 | Target bank |
| dpeValid | input | 1 | Dot product beat valid |
| dpeReady | output | 1 | Dot product beat taken |
| dpeData | input | 32 | Dot product partial sum |
| redInValid | input | 1 | Incoming reduction beat valid |
| redInReady | output | 1 | Incoming reduction beat taken |
| redInData | input | 32 | Incoming reduction partial |
| redOutValid | output | 1 | Outgoing reduction beat valid |
| redOutReady | input | 1 | Neighbour takes the beat |
| redOutData | output | 32 | Outgoing reduction lane value |
| resValid | output | 1 | Result beat valid |
| resReady | input | 1 | Downstream takes the beat |
| resData | output | 32 | Result lane value |

## Verification
The dot product stream and the incoming reduction stream can write the very same lane of the same bank in one cycle. The bench issues an accumulate and a remote add to one bank and then drives both streams in lockstep so every beat pair lands together; a following drain must show the bias plus both contributions in each lane. A second clash, a command arriving for a bank whose drain is stalled by back-pressure, is provoked by holding the result ready low and judged by `cmdReady` for that bank and for another bank.

// File: rtl/bred_pkg.sv
package bred_pkg;
  localparam int NUM_BANKS = 4;
  localparam int LANES     = 32;
  localparam int DATA_W    = 32;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int LANE_W    = $clog2(LANES);
  localparam int NUM_ENG   = 4;

  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_BIAS  = 3'd1,
    OP_ACC   = 3'd2,
    OP_SEND  = 3'd3,
    OP_RADD  = 3'd4,
    OP_DRAIN = 3'd5
  } op_e;

  // engine slots
  localparam int ENG_DPE   = 0;
  localparam int ENG_RIN   = 1;
  localparam int ENG_SEND  = 2;
  localparam int ENG_DRAIN = 3;

  typedef struct packed {
    logic              dpeWr;
    logic              dpeLoad;
    logic [BANK_W-1:0] dpeBank;
    logic [LANE_W-1:0] dpeLane;
    logic              redWr;
    logic [BANK_W-1:0] redBank;
    logic [LANE_W-1:0] redLane;
    logic              clrEn;
    logic [BANK_W-1:0] clrBank;
    logic [BANK_W-1:0] sendBank;
    logic [LANE_W-1:0] sendLane;
    logic [BANK_W-1:0] drainBank;
    logic [LANE_W-1:0] drainLane;
  } strobe_t;
endpackage

// File: rtl/bred_engine.sv
module bred_engine
  import bred_pkg::*;
#(
  parameter int ENG_LANES = LANES,
  localparam int EL_W = $clog2(ENG_LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BANK_W-1:0] startBank,
  input  logic              beat,
  output logic              busy,
  output logic [BANK_W-1:0] bank,
  output logic [EL_W-1:0]   lane
);
  logic lastBeat;
  assign lastBeat = (lane == EL_W'(ENG_LANES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      bank <= '0;
      lane <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        bank <= startBank;
        lane <= '0;
      end
    end else if (beat) begin
      if (lastBeat) begin
        busy <= 1'b0;
        lane <= '0;
      end else begin
        lane <= lane + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bred_ctrl.sv
module bred_ctrl
  import bred_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              dpeValid,
  output logic              dpeReady,
  input  logic              redInValid,
  output logic              redInReady,
  output logic              redOutValid,
  input  logic              redOutReady,
  output logic              resValid,
  input  logic              resReady,
  output strobe_t           st
);
  logic [NUM_ENG-1:0] busy;
  logic [NUM_ENG-1:0] start;
  logic [NUM_ENG-1:0] beat;
  logic [BANK_W-1:0]  engBank [NUM_ENG];
  logic [LANE_W-1:0]  engLane [NUM_ENG];

  logic       needsEng;
  logic [1:0] engIdx;
  logic       readsBank;
  logic       readHold;
  logic       writeHold;
  logic       engFree;
  logic       accept;
  logic       dpeLoadQ;

  always_comb begin
    needsEng  = 1'b1;
    engIdx    = 2'(ENG_DPE);
    readsBank = 1'b0;
    unique case (cmdOp)
      OP_BIAS, OP_ACC: engIdx = 2'(ENG_DPE);
      OP_RADD:         engIdx = 2'(ENG_RIN);
      OP_SEND:  begin engIdx = 2'(ENG_SEND);  readsBank = 1'b1; end
      OP_DRAIN: begin engIdx = 2'(ENG_DRAIN); readsBank = 1'b1; end
      OP_CLEAR: begin needsEng = 1'b0; readsBank = 1'b1; end
      default:  needsEng = 1'b0;
    endcase
  end

  assign readHold  = (busy[ENG_SEND]  && engBank[ENG_SEND]  == cmdBank) ||
                     (busy[ENG_DRAIN] && engBank[ENG_DRAIN] == cmdBank);
  assign writeHold = (busy[ENG_DPE] && engBank[ENG_DPE] == cmdBank) ||
                     (busy[ENG_RIN] && engBank[ENG_RIN] == cmdBank);
  assign engFree   = !needsEng || !busy[engIdx];
  assign cmdReady  = !readHold && engFree && !(readsBank && writeHold);
  assign accept    = cmdValid && cmdReady;

  always_comb begin
    for (int k = 0; k < NUM_ENG; k++) begin
      start[k] = accept && needsEng && (engIdx == 2'(k));
    end
  end

  assign beat[ENG_DPE]   = busy[ENG_DPE]   && dpeValid;
  assign beat[ENG_RIN]   = busy[ENG_RIN]   && redInValid;
  assign beat[ENG_SEND]  = busy[ENG_SEND]  && redOutReady;
  assign beat[ENG_DRAIN] = busy[ENG_DRAIN] && resReady;

  generate
    for (genvar k = 0; k < NUM_ENG; k++) begin : gEng
      bred_engine #(.ENG_LANES(LANES)) uEng (
        .clk      (clk),
        .rstN     (rstN),
        .start    (start[k]),
        .startBank(cmdBank),
        .beat     (beat[k]),
        .busy     (busy[k]),
        .bank     (engBank[k]),
        .lane     (engLane[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) dpeLoadQ <= 1'b0;
    else if (start[ENG_DPE]) dpeLoadQ <= (cmdOp == OP_BIAS);
  end

  assign dpeReady    = busy[ENG_DPE];
  assign redInReady  = busy[ENG_RIN];
  assign redOutValid = busy[ENG_SEND];
  assign resValid    = busy[ENG_DRAIN];

  always_comb begin
    st.dpeWr     = beat[ENG_DPE];
    st.dpeLoad   = dpeLoadQ;
    st.dpeBank   = engBank[ENG_DPE];
    st.dpeLane   = engLane[ENG_DPE];
    st.redWr     = beat[ENG_RIN];
    st.redBank   = engBank[ENG_RIN];
    st.redLane   = engLane[ENG_RIN];
    st.clrEn     = accept && (cmdOp == OP_CLEAR);
    st.clrBank   = cmdBank;
    st.sendBank  = engBank[ENG_SEND];
    st.sendLane  = engLane[ENG_SEND];
    st.drainBank = engBank[ENG_DRAIN];
    st.drainLane = engLane[ENG_DRAIN];
  end
endmodule

// File: rtl/bred_dpath.sv
module bred_dpath
  import bred_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] dpeData,
  input  logic [DATA_W-1:0] redInData,
  output logic [DATA_W-1:0] redOutData,
  output logic [DATA_W-1:0] resData
);
  logic [DATA_W-1:0] mem     [NUM_BANKS][LANES];
  logic [DATA_W-1:0] memNext [NUM_BANKS][LANES];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        logic dHit;
        logic rHit;
        logic cHit;
        logic [DATA_W-1:0] v;
        dHit = st.dpeWr && st.dpeBank == BANK_W'(b) && st.dpeLane == LANE_W'(l);
        rHit = st.redWr && st.redBank == BANK_W'(b) && st.redLane == LANE_W'(l);
        cHit = st.clrEn && st.clrBank == BANK_W'(b);
        v = mem[b][l];
        if (dHit && st.dpeLoad) v = dpeData;
        else if (dHit)          v = v + dpeData;
        if (rHit)               v = v + redInData;
        if (cHit)               v = '0;
        memNext[b][l] = v;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (!rstN) mem[b][l] <= '0;
        else       mem[b][l] <= memNext[b][l];
      end
    end
  end

  assign redOutData = mem[st.sendBank][st.sendLane];
  assign resData    = mem[st.drainBank][st.drainLane];
endmodule

// File: rtl/banked_reducer.sv
module banked_reducer
  import bred_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              dpeValid,
  output logic              dpeReady,
  input  logic [DATA_W-1:0] dpeData,
  input  logic              redInValid,
  output logic              redInReady,
  input  logic [DATA_W-1:0] redInData,
  output logic              redOutValid,
  input  logic              redOutReady,
  output logic [DATA_W-1:0] redOutData,
  output logic              resValid,
  input  logic              resReady,
  output logic [DATA_W-1:0] resData
);
  strobe_t st;

  bred_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .cmdOp      (cmdOp),
    .cmdBank    (cmdBank),
    .dpeValid   (dpeValid),
    .dpeReady   (dpeReady),
    .redInValid (redInValid),
    .redInReady (redInReady),
    .redOutValid(redOutValid),
    .redOutReady(redOutReady),
    .resValid   (resValid),
    .resReady   (resReady),
    .st         (st)
  );

  bred_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .dpeData   (dpeData),
    .redInData (redInData),
    .redOutData(redOutData),
    .resData   (resData)
  );
endmodule

// File: rtl/banked_reducer_chk.sv
module banked_reducer_chk
  import bred_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [2:0]        cmdOp,
  input logic [BANK_W-1:0] cmdBank,
  input logic              dpeReady,
  input logic              redOutValid,
  input logic              redOutReady,
  input logic [DATA_W-1:0] redOutData,
  input logic              resValid,
  input logic              resReady,
  input logic [DATA_W-1:0] resData,
  input logic [BANK_W-1:0] sendBank,
  input logic [BANK_W-1:0] drainBank
);
  logic [LANE_W:0] resCount;

  always_ff @(posedge clk) begin
    if (!rstN) resCount <= '0;
    else if (cmdValid && cmdReady && cmdOp == OP_DRAIN) resCount <= '0;
    else if (resValid && resReady) resCount <= resCount + 1'b1;
  end

  assert_hold_res_R11: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resData));

  assert_hold_red_R11: assert property (@(posedge clk) disable iff (!rstN)
    redOutValid && !redOutReady |=> redOutValid && $stable(redOutData));

  assert_stall_drain_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && resValid && cmdBank == drainBank |-> !cmdReady);

  assert_stall_send_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && redOutValid && cmdBank == sendBank |-> !cmdReady);

  assert_drain_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdOp == OP_DRAIN |=> resValid);

  assert_full_drain_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resValid) |-> resCount == (LANE_W+1)'(LANES));

  assert_dpe_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpeReady) |-> $past(cmdValid && cmdReady && (cmdOp == OP_BIAS || cmdOp == OP_ACC)));
endmodule

bind banked_reducer banked_reducer_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdOp      (cmdOp),
  .cmdBank    (cmdBank),
  .dpeReady   (dpeReady),
  .redOutValid(redOutValid),
  .redOutReady(redOutReady),
  .redOutData (redOutData),
  .resValid   (resValid),
  .resReady   (resReady),
  .resData    (resData),
  .sendBank   (st.sendBank),
  .drainBank  (st.drainBank)
);

// File: tb/banked_reducer_test.sv
`timescale 1ns/1ps
module banked_reducer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [1:0]  cmdBank = '0;
  logic        dpeValid = 1'b0;
  logic        dpeReady;
  logic [31:0] dpeData = '0;
  logic        redInValid = 1'b0;
  logic        redInReady;
  logic [31:0] redInData = '0;
  logic        redOutValid;
  logic        redOutReady = 1'b0;
  logic [31:0] redOutData;
  logic        resValid;
  logic        resReady = 1'b0;
  logic [31:0] resData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  logic [31:0] model [4][32];

  always #2.5 clk = ~clk;

  banked_reducer uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] seed, input int lane);
    return seed + 32'(lane) * 32'h0400_0001;
  endfunction

  task automatic sendCmd(input int op, input int bank);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdBank = 2'(bank);
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic driveStream(input bit toRed, input logic [31:0] seed,
                             input int first, input int count);
    for (int l = first; l < first + count; l++) begin
      @(negedge clk);
      if (toRed) begin redInValid = 1'b1; redInData = pat(seed, l); end
      else       begin dpeValid = 1'b1;   dpeData = pat(seed, l);   end
      while (!(toRed ? redInReady : dpeReady)) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    if (toRed) redInValid = 1'b0; else dpeValid = 1'b0;
  endtask

  task automatic collect(input bit fromRed, input int bank, input bit bp, input string req);
    int l = 0;
    int cyc = 0;
    bit stalled = 0;
    bit dataOk = 1;
    bit holdOk = 1;
    logic [31:0] held = '0;
    logic [31:0] badAct = '0;
    logic [31:0] badExp = '0;
    while (l < 32 && cyc < 400) begin
      logic rdy;
      logic v;
      logic [31:0] d;
      @(negedge clk);
      v = fromRed ? redOutValid : resValid;
      d = fromRed ? redOutData : resData;
      if (stalled && d !== held) holdOk = 0;
      rdy = bp ? (cyc % 3 != 0) : 1'b1;
      if (fromRed) redOutReady = rdy; else resReady = rdy;
      if (v && rdy) begin
        if (d !== model[bank][l] && dataOk) begin
          dataOk = 0; badAct = d; badExp = model[bank][l];
        end
        l++;
        stalled = 0;
      end else if (v) begin
        stalled = 1; held = d;
      end
      cyc++;
      @(posedge clk);
    end
    @(negedge clk);
    if (fromRed) redOutReady = 1'b0; else resReady = 1'b0;
    check(dataOk && l == 32, req, $sformatf("lane values of bank %0d", bank), badAct, badExp);
    if (bp) check(holdOk, "R11", "data held while stalled", 32'(holdOk), 32'd1);
    check((fromRed ? redOutValid : resValid) == 1'b0, "R12",
          "valid low after 32nd beat", 32'(fromRed ? redOutValid : resValid), 32'd0);
  endtask

  task automatic drainCheck(input int bank, input bit bp, input string req);
    sendCmd(5, bank);
    collect(0, bank, bp, req);
  endtask

  task automatic modelAdd(input int bank, input logic [31:0] seed);
    for (int l = 0; l < 32; l++) model[bank][l] = model[bank][l] + pat(seed, l);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dpeReady == 0 && redInReady == 0, "R1", "input readies after reset",
          {30'd0, dpeReady, redInReady}, 32'd0);
    check(redOutValid == 0 && resValid == 0, "R1", "output valids after reset",
          {30'd0, redOutValid, resValid}, 32'd0);
    check(cmdReady == 1, "R1", "cmdReady after reset", 32'(cmdReady), 32'd1);
    for (int b = 0; b < 4; b++) drainCheck(b, 0, "R1");
  endtask

  task automatic testBiasAcc();
    sendCmd(1, 1);
    driveStream(0, 32'h7FFF_FFF0, 0, 32);
    for (int l = 0; l < 32; l++) model[1][l] = pat(32'h7FFF_FFF0, l);
    drainCheck(1, 0, "R3");
    sendCmd(2, 1);
    driveStream(0, 32'h7FFF_FFF0, 0, 32);
    modelAdd(1, 32'h7FFF_FFF0);
    sendCmd(2, 1);
    driveStream(0, 32'h1234_5678, 0, 32);
    modelAdd(1, 32'h1234_5678);
    drainCheck(1, 1, "R4");
  endtask

  task automatic testIndependence();
    sendCmd(1, 2);
    driveStream(0, 32'h0000_0100, 0, 32);
    for (int l = 0; l < 32; l++) model[2][l] = pat(32'h0000_0100, l);
    sendCmd(1, 3);
    driveStream(0, 32'hA000_0000, 0, 32);
    for (int l = 0; l < 32; l++) model[3][l] = pat(32'hA000_0000, l);
    drainCheck(1, 0, "R8");
    drainCheck(0, 0, "R8");
  endtask

  task automatic testSend();
    sendCmd(3, 1);
    collect(1, 1, 1, "R5");
    drainCheck(1, 0, "R5");
  endtask

  task automatic testRemoteAdd();
    sendCmd(4, 2);
    driveStream(1, 32'hFFFF_FF00, 0, 32);
    modelAdd(2, 32'hFFFF_FF00);
    drainCheck(2, 0, "R6");
  endtask

  task automatic testClearUnused();
    sendCmd(0, 3);
    for (int l = 0; l < 32; l++) model[3][l] = '0;
    drainCheck(3, 0, "R2");
    sendCmd(7, 2);
    sendCmd(6, 2);
    drainCheck(2, 0, "R13");
  endtask

  task automatic testStall();
    sendCmd(5, 0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2; cmdBank = 2'd0;
    #1;
    check(cmdReady == 0, "R9", "accumulate to draining bank held", 32'(cmdReady), 32'd0);
    cmdOp = 3'd0; cmdBank = 2'd1;
    #1;
    check(cmdReady == 1, "R9", "clear to other bank accepted", 32'(cmdReady), 32'd1);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    for (int l = 0; l < 32; l++) model[1][l] = '0;
    fork
      sendCmd(2, 0);
      collect(0, 0, 1, "R9");
    join
    driveStream(0, 32'h0BAD_0001, 0, 32);
    modelAdd(0, 32'h0BAD_0001);
    drainCheck(0, 0, "R9");
    drainCheck(1, 0, "R2");
  endtask

  task automatic testCoincide();
    sendCmd(1, 3);
    driveStream(0, 32'h0000_0011, 0, 32);
    for (int l = 0; l < 32; l++) model[3][l] = pat(32'h0000_0011, l);
    sendCmd(2, 3);
    sendCmd(4, 3);
    fork
      driveStream(0, 32'h8000_0003, 0, 32);
      driveStream(1, 32'h9000_0005, 0, 32);
    join
    modelAdd(3, 32'h8000_0003);
    modelAdd(3, 32'h9000_0005);
    drainCheck(3, 0, "R10");
  endtask

  task automatic testBeatCount();
    sendCmd(2, 1);
    driveStream(0, 32'h0000_0777, 0, 31);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2; cmdBank = 2'd2;
    #1;
    check(dpeReady == 1, "R12", "stream open after 31 beats", 32'(dpeReady), 32'd1);
    check(cmdReady == 0, "R12", "second accumulate held", 32'(cmdReady), 32'd0);
    cmdValid = 1'b0;
    driveStream(0, 32'h0000_0777, 31, 1);
    check(dpeReady == 0, "R12", "stream closed after 32 beats", 32'(dpeReady), 32'd0);
    cmdValid = 1'b1;
    #1;
    check(cmdReady == 1, "R12", "accumulate accepted once free", 32'(cmdReady), 32'd1);
    cmdValid = 1'b0;
    modelAdd(1, 32'h0000_0777);
    drainCheck(1, 0, "R4");
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < 32; l++) model[b][l] = '0;
    testReset();
    testBiasAcc();
    testIndependence();
    testSend();
    testRemoteAdd();
    testClearUnused();
    testStall();
    testCoincide();
    testBeatCount();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule